// File: doc/BRIEF.md
# Subtract-and-Skip Single-Instruction Core

This block is a tiny processor core with only one operation. Every instruction word holds a single value: the byte address of a data operand. Executing it replaces the accumulator with the operand word minus the accumulator and writes that difference back to the operand location as well. When the subtraction borrows, the core skips the following instruction. The core has no program-counter register. The program counter lives in memory word 0, so every step reads it from there, advances it and stores it back. A program can therefore redirect control flow by using word 0 as its operand.

The core drives one single-port synchronous memory through a word-wide address, write data, write enable and read data. Read data appears in the cycle after the address is presented. The surrounding system preloads the program, releases reset and pulses `start`. The core then runs until it halts. Parameters set the word width (a multiple of 8 bits, from 8 to 64), the memory address width, whether a low program counter halts the core, and whether the accumulator is mirrored into memory word 1.

Top module: `ssk_core`

## Requirements
- R1: After reset the core is idle, `acc` is 0, `halted` is low and no memory write occurs until a `start` pulse arrives. `start` has an effect only while the core is idle.
- R2: Each instruction first reads word 0 and writes back that value plus WORD_W/8 before the operand is read. The instruction word is then fetched at the old value.
- R3: The instruction word is taken whole as a byte address. The memory word index is that byte address divided by WORD_W/8.
- R4: The new accumulator equals the operand word minus the old accumulator, modulo 2^WORD_W. The same value is written to the operand's memory word and to `acc`.
- R5: A borrow means the operand, read as unsigned, is smaller than the old accumulator. On a borrow, word 0 is read again after the result write and advanced by one more WORD_W/8. That second read sees any change the result write made to word 0.
- R6: With HALT_LOW_PC=1, a value of 4 or less fetched from word 0 halts the core with no memory write. `halted` then stays high and the memory stays untouched until reset, even if `start` is pulsed again.
- R7: With MIRROR_ACC=1, each new accumulator is also written to word 1 (byte address WORD_W/8) in the cycle after the result write. With MIRROR_ACC=0, word 1 is not written by the mirror.
- R8: All program-counter arithmetic wraps modulo 2^WORD_W.
- R9: `pc` holds the value most recently fetched from word 0 at the start of an instruction, including the value that caused a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts execution from idle |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once the halt condition has been met |
| pc | output | WORD_W | Program counter value last fetched from word 0 |
| acc | output | WORD_W | Accumulator |

## Verification
The sharpest overlap happens when the result write and the program-counter update both target word 0. An instruction whose operand is word 0 overwrites the program counter with its difference. If that same subtraction borrows, the skip must advance the freshly written value, not the value fetched at the start of the instruction. A directed program makes this happen twice: once with a borrow and once without. The bench judges it by the final accumulator, the final word 0 and `pc`, all worked out by hand. Wide sweeps of operand and accumulator pairs, including equal values and values one apart, run a program placed at the top of memory. This makes the program counter wrap past zero into the halt range. The final memory and accumulator are compared with an independent step model, both with and without the mirror.

// File: rtl/ssk_pkg.sv
package ssk_pkg;

  // Sequencing states; one memory access per state.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PC_RD,
    ST_PC_WR,
    ST_INSTR_RD,
    ST_OPND_RD,
    ST_RESULT_WR,
    ST_MIRROR_WR,
    ST_SKIP_RD,
    ST_SKIP_WR,
    ST_HALTED
  } ssk_state_e;

  // A fetched program counter at or below this value stops the core.
  localparam int unsigned SSK_HALT_LIMIT = 4;

endpackage

// File: rtl/ssk_word_index.sv
module ssk_word_index #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [WORD_W-1:0] byte_addr,
  output logic [ADDR_W-1:0] word_idx
);

  localparam int unsigned BYTES = WORD_W / 8;
  localparam int unsigned SHIFT = $clog2(BYTES);
  localparam bit          POW2  = ((1 << SHIFT) == BYTES);

  logic [WORD_W-1:0] scaled;

  generate
    if (POW2) begin : g_shift
      assign scaled = byte_addr >> SHIFT;
    end else begin : g_div
      assign scaled = byte_addr / WORD_W'(BYTES);
    end

    if (ADDR_W < WORD_W) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^scaled[WORD_W-1:ADDR_W];
      assign word_idx  = scaled[ADDR_W-1:0];
    end else begin : g_full
      assign word_idx = ADDR_W'(scaled);
    end
  endgenerate

endmodule

// File: rtl/ssk_datapath.sv
module ssk_datapath
  import ssk_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 10,
  parameter bit          HALT_LOW_PC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssk_state_e        state,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] acc_q,
  output logic [WORD_W-1:0] pc_q,
  output logic [ADDR_W-1:0] opnd_idx_q,
  output logic              borrow_q,
  output logic              borrow_now,
  output logic [WORD_W-1:0] diff,
  output logic [WORD_W-1:0] pc_step,
  output logic              halt_hit,
  output logic [ADDR_W-1:0] instr_idx,
  output logic [ADDR_W-1:0] opnd_idx
);

  localparam int unsigned BYTES = WORD_W / 8;

  // Difference with the borrow as the extra top bit.
  function automatic logic [WORD_W:0] sub_with_borrow(
    input logic [WORD_W-1:0] opnd,
    input logic [WORD_W-1:0] cur_acc
  );
    return {1'b0, opnd} - {1'b0, cur_acc};
  endfunction

  // One word forward, wrapping at the word width.
  function automatic logic [WORD_W-1:0] advance_pc(input logic [WORD_W-1:0] p);
    return p + WORD_W'(BYTES);
  endfunction

  logic [WORD_W:0] sub_res;

  assign sub_res    = sub_with_borrow(mem_rdata, acc_q);
  assign diff       = sub_res[WORD_W-1:0];
  assign borrow_now = sub_res[WORD_W];
  assign pc_step    = advance_pc(mem_rdata);
  assign halt_hit   = HALT_LOW_PC && (mem_rdata <= WORD_W'(SSK_HALT_LIMIT));

  ssk_word_index #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_instr_idx (
    .byte_addr (pc_q),
    .word_idx  (instr_idx)
  );

  ssk_word_index #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_opnd_idx (
    .byte_addr (mem_rdata),
    .word_idx  (opnd_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      pc_q       <= '0;
      opnd_idx_q <= '0;
      borrow_q   <= 1'b0;
    end else begin
      if (state == ST_PC_WR)     pc_q <= mem_rdata;
      if (state == ST_OPND_RD)   opnd_idx_q <= opnd_idx;
      if (state == ST_RESULT_WR) begin
        acc_q    <= diff;
        borrow_q <= borrow_now;
      end
    end
  end

endmodule

// File: rtl/ssk_sequencer.sv
module ssk_sequencer
  import ssk_pkg::*;
#(
  parameter bit MIRROR_ACC = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       halt_hit,
  input  logic       borrow_now,
  input  logic       borrow_q,
  output ssk_state_e state
);

  ssk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (start) nxt = ST_PC_RD;
      ST_PC_RD:     nxt = ST_PC_WR;
      ST_PC_WR:     nxt = halt_hit ? ST_HALTED : ST_INSTR_RD;
      ST_INSTR_RD:  nxt = ST_OPND_RD;
      ST_OPND_RD:   nxt = ST_RESULT_WR;
      ST_RESULT_WR: begin
        if (MIRROR_ACC) nxt = ST_MIRROR_WR;
        else            nxt = borrow_now ? ST_SKIP_RD : ST_PC_RD;
      end
      ST_MIRROR_WR: nxt = borrow_q ? ST_SKIP_RD : ST_PC_RD;
      ST_SKIP_RD:   nxt = ST_SKIP_WR;
      ST_SKIP_WR:   nxt = ST_PC_RD;
      ST_HALTED:    nxt = ST_HALTED;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/ssk_core.sv
module ssk_core
  import ssk_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 10,
  parameter bit          HALT_LOW_PC = 1'b1,
  parameter bit          MIRROR_ACC  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] acc
);

  localparam logic [ADDR_W-1:0] PC_WORD     = '0;
  localparam logic [ADDR_W-1:0] MIRROR_WORD = ADDR_W'(1);

  ssk_state_e        state;
  logic [WORD_W-1:0] acc_q, pc_q, diff, pc_step;
  logic [ADDR_W-1:0] opnd_idx_q, instr_idx, opnd_idx;
  logic              borrow_q, borrow_now, halt_hit;

  // Named events for the checker.
  logic idle_evt, pc_wr_evt, res_evt, mir_evt, skip_rd_evt, skip_wr_evt;
  assign idle_evt    = (state == ST_IDLE);
  assign pc_wr_evt   = (state == ST_PC_WR);
  assign res_evt     = (state == ST_RESULT_WR);
  assign mir_evt     = (state == ST_MIRROR_WR);
  assign skip_rd_evt = (state == ST_SKIP_RD);
  assign skip_wr_evt = (state == ST_SKIP_WR);

  ssk_sequencer #(.MIRROR_ACC(MIRROR_ACC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .halt_hit   (halt_hit),
    .borrow_now (borrow_now),
    .borrow_q   (borrow_q),
    .state      (state)
  );

  ssk_datapath #(
    .WORD_W      (WORD_W),
    .ADDR_W      (ADDR_W),
    .HALT_LOW_PC (HALT_LOW_PC)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .mem_rdata  (mem_rdata),
    .acc_q      (acc_q),
    .pc_q       (pc_q),
    .opnd_idx_q (opnd_idx_q),
    .borrow_q   (borrow_q),
    .borrow_now (borrow_now),
    .diff       (diff),
    .pc_step    (pc_step),
    .halt_hit   (halt_hit),
    .instr_idx  (instr_idx),
    .opnd_idx   (opnd_idx)
  );

  // Memory port steering, one access per state.
  always_comb begin
    mem_addr  = PC_WORD;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state)
      ST_PC_WR: begin
        mem_we    = !halt_hit;
        mem_wdata = pc_step;
      end
      ST_INSTR_RD: mem_addr = instr_idx;
      ST_OPND_RD:  mem_addr = opnd_idx;
      ST_RESULT_WR: begin
        mem_addr  = opnd_idx_q;
        mem_we    = 1'b1;
        mem_wdata = diff;
      end
      ST_MIRROR_WR: begin
        mem_addr  = MIRROR_WORD;
        mem_we    = 1'b1;
        mem_wdata = acc_q;
      end
      ST_SKIP_WR: begin
        mem_we    = 1'b1;
        mem_wdata = pc_step;
      end
      default: ;
    endcase
  end

  assign halted = (state == ST_HALTED);
  assign pc     = pc_q;
  assign acc    = acc_q;

endmodule

// File: rtl/ssk_core_chk.sv
module ssk_core_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] acc,
  input logic              idle_evt,
  input logic              pc_wr_evt,
  input logic              res_evt,
  input logic              mir_evt,
  input logic              skip_rd_evt,
  input logic              skip_wr_evt,
  input logic              borrow_q
);

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |-> !mem_we); // R1

  AST_PC_WORD_WRITERS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == '0) |-> (pc_wr_evt || skip_wr_evt || res_evt)); // R2

  AST_RESULT_TO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    res_evt |=> (acc == $past(mem_wdata))); // R4

  AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_evt |=> $stable(acc)); // R4

  AST_SKIP_NEEDS_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    skip_rd_evt |-> borrow_q); // R5

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R6

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R6

  AST_MIRROR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mir_evt |-> ($past(res_evt) && mem_addr == ADDR_W'(1)
                 && mem_wdata == $past(mem_wdata))); // R7

endmodule

bind ssk_core ssk_core_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halted      (halted),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .acc         (acc),
  .idle_evt    (idle_evt),
  .pc_wr_evt   (pc_wr_evt),
  .res_evt     (res_evt),
  .mir_evt     (mir_evt),
  .skip_rd_evt (skip_rd_evt),
  .skip_wr_evt (skip_wr_evt),
  .borrow_q    (borrow_q)
);

// File: tb/test_ssk_core.sv
module test_ssk_core;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] addr_a, wd_a, rd_a, pc_a, acc_a;
  logic [7:0] addr_b, wd_b, rd_b, pc_b, acc_b;
  logic       we_a, we_b, halted_a, halted_b;

  logic [7:0] mem_a [256];
  logic [7:0] mem_b [256];
  logic [7:0] img   [256];
  logic [7:0] ref_m [256];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  ssk_core #(.WORD_W(8), .ADDR_W(8), .HALT_LOW_PC(1'b1), .MIRROR_ACC(1'b0)) i_ssk_core (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(addr_a), .mem_we(we_a), .mem_wdata(wd_a), .mem_rdata(rd_a),
    .halted(halted_a), .pc(pc_a), .acc(acc_a));

  ssk_core #(.WORD_W(8), .ADDR_W(8), .HALT_LOW_PC(1'b1), .MIRROR_ACC(1'b1)) i_ssk_core_mir (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(addr_b), .mem_we(we_b), .mem_wdata(wd_b), .mem_rdata(rd_b),
    .halted(halted_b), .pc(pc_b), .acc(acc_b));

  always @(posedge clk) begin
    if (we_a) mem_a[addr_a] <= wd_a;
    rd_a <= mem_a[addr_a];
    if (we_b) mem_b[addr_b] <= wd_b;
    rd_b <= mem_b[addr_b];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  task automatic load_and_reset();
    rst_n = 1'b0;
    start = 1'b0;
    for (int i = 0; i < 256; i++) begin
      mem_a[i] = img[i];
      mem_b[i] = img[i];
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic go_and_wait();
    int t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!(halted_a && halted_b) && t < 3000) begin
      @(negedge clk);
      t++;
    end
  endtask

  // Independent step model of the instruction rule (byte == word for 8-bit).
  task automatic ref_run(input bit mir, output logic [7:0] racc);
    for (int i = 0; i < 256; i++) ref_m[i] = img[i];
    racc = 8'h00;
    for (int s = 0; s < 400; s++) begin
      logic [7:0] p, op, d;
      logic       b;
      p = ref_m[0];
      if (p <= 8'd4) break;
      ref_m[0] = p + 8'd1;
      op = ref_m[p];
      d  = ref_m[op];
      b  = (d < racc);
      racc = d - racc;
      ref_m[op] = racc;
      if (mir) ref_m[1] = racc;
      if (b) ref_m[0] = ref_m[0] + 8'd1;
    end
  endtask

  task automatic compare_model();
    logic [7:0] ra, rb;
    int mis;
    ref_run(1'b0, ra);
    check("R4", "acc vs model", int'(acc_a), int'(ra));
    mis = 0;
    for (int i = 0; i < 256; i++) if (mem_a[i] !== ref_m[i]) mis++;
    check("R2 R3 R5 R8", "memory words differing from model", mis, 0);
    ref_run(1'b1, rb);
    check("R4", "mirror core acc vs model", int'(acc_b), int'(rb));
    mis = 0;
    for (int i = 0; i < 256; i++) if (mem_b[i] !== ref_m[i]) mis++;
    check("R7", "mirror memory words differing from model", mis, 0);
    check("R6", "both halted", int'(halted_a && halted_b), 1);
  endtask

  // Program at the top of memory: the PC wraps into the halt range.
  task automatic sweep_case(input logic [7:0] a, input logic [7:0] x);
    logic [7:0] c, e1, exp_acc;
    c  = a ^ x ^ 8'h5A;
    e1 = x - a;
    exp_acc = (x < a) ? e1 : (c - e1);
    clear_img();
    img[0]   = 8'd253;
    img[253] = 8'd200;
    img[254] = 8'd201;
    img[255] = 8'd202;
    img[200] = a;
    img[201] = x;
    img[202] = c;
    load_and_reset();
    go_and_wait();
    check("R4 R5", "sweep acc", int'(acc_a), int'(exp_acc));
    check("R8", "sweep final word 0 small", int'(mem_a[0] <= 8'd4), 1);
    compare_model();
  endtask

  initial begin
    int idle_writes;

    // R1: idle after reset, no writes without start
    clear_img();
    img[0]  = 8'd20;
    img[20] = 8'd30;
    img[30] = 8'd9;
    load_and_reset();
    idle_writes = 0;
    for (int k = 0; k < 10; k++) begin
      if (we_a || we_b) idle_writes++;
      @(negedge clk);
    end
    check("R1", "writes while idle", idle_writes, 0);
    check("R1", "acc after reset", int'(acc_a), 0);
    check("R1", "halted after reset", int'(halted_a), 0);
    check("R1", "word 0 untouched before start", int'(mem_a[0]), 20);
    go_and_wait();
    compare_model();

    // R6 R9: PC of 3 halts at once, nothing written
    clear_img();
    img[0] = 8'd3;
    load_and_reset();
    go_and_wait();
    check("R6", "halted on low PC", int'(halted_a), 1);
    check("R6", "word 0 unchanged at halt", int'(mem_a[0]), 3);
    check("R9", "pc shows halting value", int'(pc_a), 3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check("R6", "still halted after start and wait", int'(halted_a), 1);
    check("R6", "acc untouched while halted", int'(acc_a), 0);
    check("R6", "word 0 untouched while halted", int'(mem_a[0]), 3);

    // R6 boundary: PC of 5 runs; program ends with acc 1
    clear_img();
    img[0] = 8'd5;
    load_and_reset();
    go_and_wait();
    check("R6", "PC 5 executes, final acc", int'(acc_a), 1);
    check("R6", "PC 5 final word 0", int'(mem_a[0]), 1);
    compare_model();

    // R5 R9 R7: result write to word 0 followed by a skip re-read
    clear_img();
    img[0]  = 8'd10;
    img[10] = 8'd50;
    img[50] = 8'd200;
    img[11] = 8'd0;
    img[69] = 8'd0;
    load_and_reset();
    go_and_wait();
    check("R5", "skip after PC overwrite, acc", int'(acc_a), 2);
    check("R5", "skip after PC overwrite, word 0", int'(mem_a[0]), 2);
    check("R9", "pc after PC overwrite", int'(pc_a), 2);
    check("R7", "mirror word 1", int'(mem_b[1]), 2);
    check("R7", "no mirror word 1", int'(mem_a[1]), 0);
    compare_model();

    // Near-exhaustive sweep over operand/accumulator pairs
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        sweep_case(8'(i * 17), 8'(j * 17));
    // Borrow boundary: equal and one below
    for (int k = 1; k < 256; k += 3) begin
      sweep_case(8'(k), 8'(k - 1));
      sweep_case(8'(k), 8'(k));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule